// File: doc/BRIEF.md
# Serial channel buffer status tracker

This block keeps the status of one serial transmit/receive channel: whether a transfer is running, whether the channel's single data buffer holds valid data, and which errors have been seen. The datapath around it owns the buffer, the shift register and the framing logic. It reports its events to this block as single-cycle strobes. The block returns a 16-bit read-only status word and a one-cycle discard pulse that tells the datapath to drop the data it holds.

The buffer-valid flag follows the direction of traffic. While transmitting, it drops when the buffer contents move into the shift register. While receiving, it drops when the buffer is read. Writing to a buffer that is already full is an overrun: the held data is discarded and a sticky overrun flag is raised. A build parameter removes the three error flags entirely for channels that have no use for them.

Top module: `chan_status_tracker`

## Requirements
- R1: After a synchronous reset, `status_word` is 0x0000 and `discard` is 0.
- R2: In `status_word`, bit 6 is the busy flag, bit 5 is the buffer-valid flag, bit 2 is the framing error, bit 1 is the parity error and bit 0 is the overrun error. Every other bit always reads 0.
- R3: The busy flag is 1 in the cycle after `xfer_load`. It returns to 0 in the cycle after `xfer_done`. If both strobes come in the same cycle, `xfer_load` wins.
- R4: A `cmd_start` or `cmd_stop` pulse clears both the busy flag and the buffer-valid flag in the next cycle. This overrides every set event.
- R5: The buffer-valid flag becomes 1 in the next cycle after any of these: `buf_wr` while `tx_en` is 1, `rx_store` while `rx_en` is 1, or a reception error (`err_frame` or `err_parity`).
- R6: The buffer-valid flag becomes 0 in the next cycle after `xfer_load` while `tx_en` is 1, or after `buf_rd` while `rx_en` is 1. If a set event from R5 comes in the same cycle, the set wins.
- R7: `buf_wr` or `rx_store` while the buffer-valid flag is 1 is an overrun. In the next cycle, `discard` is 1 for exactly that one cycle and the overrun flag (bit 0) becomes 1. A start or stop command in the same cycle does not hide the overrun.
- R8: The error flags are sticky. Each one stays 1 until reset or until its bit of `err_clr` is pulsed: bit 2 clears framing, bit 1 clears parity, bit 0 clears overrun. A set and a clear of the same flag in the same cycle leave it at 1.
- R9: With `HAS_ERR_FLAGS` = 0, bits 2..0 always read 0. The busy flag, the buffer-valid flag and `discard` behave exactly as in the full build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_wr | input | 1 | Data written to the buffer |
| buf_rd | input | 1 | Buffer read by the consumer |
| tx_en | input | 1 | Transmit enabled |
| rx_en | input | 1 | Receive enabled |
| xfer_load | input | 1 | Buffer contents moved into the shift register |
| xfer_done | input | 1 | Communication operation completed |
| rx_store | input | 1 | Received data stored into the buffer |
| err_frame | input | 1 | Framing error pulse from the receiver |
| err_parity | input | 1 | Parity error pulse from the receiver |
| err_clr | input | 3 | Per-flag clear strobes (2 framing, 1 parity, 0 overrun) |
| cmd_start | input | 1 | Channel start command pulse |
| cmd_stop | input | 1 | Channel stop command pulse |
| status_word | output | 16 | Read-only status word |
| discard | output | 1 | One-cycle pulse: drop held buffer data |

## Verification
The bench targets four kinds of same-cycle collision:
- A load together with a done: a design with the wrong priority leaves busy low.
- A set together with a clear of the buffer-valid flag: a design that lets the clear win loses freshly written data.
- A command together with a write to a full buffer: a design that gates overrun by the command misses the discard.
- An error pulse together with its own clear: a design that lets the clear win drops a real error.

It also checks that a full buffer written twice in a row gives back-to-back discard pulses. A second instance built without error flags must show zeros in bits 2..0 while its other bits match the full build.

// File: rtl/sst_pkg.sv
package sst_pkg;

    localparam int STATUS_W  = 16;
    localparam int BIT_BUSY  = 6;
    localparam int BIT_BUFV  = 5;
    localparam int BIT_FRM   = 2;
    localparam int BIT_PAR   = 1;
    localparam int BIT_OVR   = 0;
    localparam int N_ERR     = 3;

    // index of each error flag inside the error vector and the clear strobe
    typedef enum int {
        ERR_OVR = 0,
        ERR_PAR = 1,
        ERR_FRM = 2
    } err_idx_e;

    typedef struct packed {
        logic busy;
        logic bufv;
        logic [N_ERR-1:0] err;
    } chan_status_t;

    typedef struct packed {
        logic frm;
        logic par;
        logic ovr;
    } err_evt_t;

    function automatic logic [STATUS_W-1:0] pack_status(chan_status_t s);
        logic [STATUS_W-1:0] w;
        w = '0;
        w[BIT_BUSY] = s.busy;
        w[BIT_BUFV] = s.bufv;
        w[BIT_FRM]  = s.err[ERR_FRM];
        w[BIT_PAR]  = s.err[ERR_PAR];
        w[BIT_OVR]  = s.err[ERR_OVR];
        return w;
    endfunction

    function automatic logic [N_ERR-1:0] evt_to_vec(err_evt_t e);
        logic [N_ERR-1:0] v;
        v[ERR_FRM] = e.frm;
        v[ERR_PAR] = e.par;
        v[ERR_OVR] = e.ovr;
        return v;
    endfunction

endpackage

// File: rtl/busy_flag_unit.sv
module busy_flag_unit (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic finish,
    input  logic cmd,
    output logic busy
);

    always_ff @(posedge clk) begin
        if (rst)         busy <= 1'b0;
        else if (cmd)    busy <= 1'b0;
        else if (launch) busy <= 1'b1;
        else if (finish) busy <= 1'b0;
    end

    AST_BUSY_CMD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cmd |=> !busy); // R4
    AST_BUSY_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (launch && !cmd) |=> busy); // R3
    AST_BUSY_FINISH: assert property (@(posedge clk) disable iff (rst)
        (finish && !launch) |=> !busy); // R3

endmodule

// File: rtl/buffer_flag_unit.sv
module buffer_flag_unit (
    input  logic clk,
    input  logic rst,
    input  logic buf_wr,
    input  logic buf_rd,
    input  logic tx_en,
    input  logic rx_en,
    input  logic xfer_load,
    input  logic rx_store,
    input  logic rx_error,
    input  logic cmd,
    output logic bufv,
    output logic ovr_evt,
    output logic discard
);

    logic set_evt;
    logic clr_evt;

    always_comb begin
        set_evt = (buf_wr & tx_en) | (rx_store & rx_en) | rx_error;
        clr_evt = (xfer_load & tx_en) | (buf_rd & rx_en);
        ovr_evt = bufv & (buf_wr | rx_store);
    end

    always_ff @(posedge clk) begin
        if (rst)          bufv <= 1'b0;
        else if (cmd)     bufv <= 1'b0;
        else if (set_evt) bufv <= 1'b1;
        else if (clr_evt) bufv <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) discard <= 1'b0;
        else     discard <= ovr_evt;
    end

    AST_BUFV_CMD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cmd |=> !bufv); // R4
    AST_BUFV_TX_SET: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && tx_en && !cmd) |=> bufv); // R5
    AST_BUFV_RX_READ: assert property (@(posedge clk) disable iff (rst)
        (buf_rd && rx_en && !cmd && !set_evt) |=> !bufv); // R6
    AST_DISCARD_ON_OVR: assert property (@(posedge clk) disable iff (rst)
        (bufv && buf_wr) |=> discard); // R7
    AST_DISCARD_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !(bufv && (buf_wr || rx_store)) |=> !discard); // R7

endmodule

// File: rtl/error_flag_unit.sv
module error_flag_unit #(
    parameter bit HAS_ERR_FLAGS = 1'b1,
    parameter int N_FLAGS       = sst_pkg::N_ERR
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_FLAGS-1:0] set_vec,
    input  logic [N_FLAGS-1:0] clr_vec,
    output logic [N_FLAGS-1:0] flags
);

    generate
        if (HAS_ERR_FLAGS) begin : g_flags
            for (genvar i = 0; i < N_FLAGS; i++) begin : g_bit
                always_ff @(posedge clk) begin
                    if (rst)             flags[i] <= 1'b0;
                    else if (set_vec[i]) flags[i] <= 1'b1;
                    else if (clr_vec[i]) flags[i] <= 1'b0;
                end

                AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
                    (flags[i] && !clr_vec[i]) |=> flags[i]); // R8
                AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                    set_vec[i] |=> flags[i]); // R8
            end
        end else begin : g_none
            logic unused_err_inputs;
            assign unused_err_inputs = ^{set_vec, clr_vec, clk, rst};
            assign flags = '0;
        end
    endgenerate

endmodule

// File: rtl/chan_status_tracker.sv
module chan_status_tracker
    import sst_pkg::*;
#(
    parameter bit HAS_ERR_FLAGS = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                buf_wr,
    input  logic                buf_rd,
    input  logic                tx_en,
    input  logic                rx_en,
    input  logic                xfer_load,
    input  logic                xfer_done,
    input  logic                rx_store,
    input  logic                err_frame,
    input  logic                err_parity,
    input  logic [N_ERR-1:0]    err_clr,
    input  logic                cmd_start,
    input  logic                cmd_stop,
    output logic [STATUS_W-1:0] status_word,
    output logic                discard
);

    logic         cmd;
    logic         ovr_evt;
    err_evt_t     evt;
    chan_status_t st;

    assign cmd = cmd_start | cmd_stop;

    busy_flag_unit u_busy (
        .clk    (clk),
        .rst    (rst),
        .launch (xfer_load),
        .finish (xfer_done),
        .cmd    (cmd),
        .busy   (st.busy)
    );

    buffer_flag_unit u_buf (
        .clk       (clk),
        .rst       (rst),
        .buf_wr    (buf_wr),
        .buf_rd    (buf_rd),
        .tx_en     (tx_en),
        .rx_en     (rx_en),
        .xfer_load (xfer_load),
        .rx_store  (rx_store),
        .rx_error  (err_frame | err_parity),
        .cmd       (cmd),
        .bufv      (st.bufv),
        .ovr_evt   (ovr_evt),
        .discard   (discard)
    );

    always_comb begin
        evt.frm = err_frame;
        evt.par = err_parity;
        evt.ovr = ovr_evt;
    end

    error_flag_unit #(
        .HAS_ERR_FLAGS (HAS_ERR_FLAGS),
        .N_FLAGS       (N_ERR)
    ) u_err (
        .clk     (clk),
        .rst     (rst),
        .set_vec (evt_to_vec(evt)),
        .clr_vec (err_clr),
        .flags   (st.err)
    );

    assign status_word = pack_status(st);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status_word & ~16'h0067) == 16'h0000); // R2
    AST_NOERR_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        HAS_ERR_FLAGS || (status_word[2:0] == 3'b000)); // R9
    AST_DISCARD_RAISES_OVR: assert property (@(posedge clk) disable iff (rst)
        (discard && HAS_ERR_FLAGS) |-> status_word[0]); // R7

endmodule

// File: tb/test_chan_status_tracker.sv
`timescale 1ns/1ps
module test_chan_status_tracker;

    logic clk = 1'b0;
    logic rst;
    logic buf_wr, buf_rd, tx_en, rx_en, xfer_load, xfer_done, rx_store;
    logic err_frame, err_parity, cmd_start, cmd_stop;
    logic [2:0]  err_clr;
    logic [15:0] sw_full, sw_none;
    logic        dis_full, dis_none;

    int checks = 0;
    int errors = 0;

    // model state
    logic m_busy, m_bufv, m_dis;
    logic [2:0] m_err;   // [2] framing, [1] parity, [0] overrun

    always #2.5 clk = ~clk;

    chan_status_tracker #(.HAS_ERR_FLAGS(1'b1)) i_chan_status_tracker (
        .clk(clk), .rst(rst), .buf_wr(buf_wr), .buf_rd(buf_rd), .tx_en(tx_en),
        .rx_en(rx_en), .xfer_load(xfer_load), .xfer_done(xfer_done),
        .rx_store(rx_store), .err_frame(err_frame), .err_parity(err_parity),
        .err_clr(err_clr), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .status_word(sw_full), .discard(dis_full));

    chan_status_tracker #(.HAS_ERR_FLAGS(1'b0)) i_chan_status_tracker_noerr (
        .clk(clk), .rst(rst), .buf_wr(buf_wr), .buf_rd(buf_rd), .tx_en(tx_en),
        .rx_en(rx_en), .xfer_load(xfer_load), .xfer_done(xfer_done),
        .rx_store(rx_store), .err_frame(err_frame), .err_parity(err_parity),
        .err_clr(err_clr), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .status_word(sw_none), .discard(dis_none));

    function automatic logic [15:0] exp_word(logic b, logic v, logic [2:0] e);
        logic [15:0] w;
        w = 16'h0000;
        w[6] = b; w[5] = v; w[2:0] = e;
        return w;
    endfunction

    task automatic idle_inputs();
        buf_wr = 0; buf_rd = 0; xfer_load = 0; xfer_done = 0; rx_store = 0;
        err_frame = 0; err_parity = 0; cmd_start = 0; cmd_stop = 0; err_clr = 3'b000;
    endtask

    task automatic model_step();
        logic cmd, bset, bclr, ovr;
        cmd  = cmd_start | cmd_stop;
        bset = (buf_wr & tx_en) | (rx_store & rx_en) | err_frame | err_parity;
        bclr = (xfer_load & tx_en) | (buf_rd & rx_en);
        ovr  = m_bufv & (buf_wr | rx_store);
        m_busy = cmd ? 1'b0 : xfer_load ? 1'b1 : xfer_done ? 1'b0 : m_busy;
        m_bufv = cmd ? 1'b0 : bset ? 1'b1 : bclr ? 1'b0 : m_bufv;
        m_err[2] = err_frame  | (m_err[2] & ~err_clr[2]);
        m_err[1] = err_parity | (m_err[1] & ~err_clr[1]);
        m_err[0] = ovr        | (m_err[0] & ~err_clr[0]);
        m_dis = ovr;
    endtask

    task automatic compare(string req);
        logic [15:0] ef, en;
        ef = exp_word(m_busy, m_bufv, m_err);
        en = exp_word(m_busy, m_bufv, 3'b000);
        checks++;
        if (sw_full !== ef || dis_full !== m_dis) begin
            errors++;
            $display("FAIL %s full: word=%h discard=%b expected word=%h discard=%b",
                     req, sw_full, dis_full, ef, m_dis);
        end
        checks++;
        if (sw_none !== en || dis_none !== m_dis) begin
            errors++;
            $display("FAIL %s R9 noerr: word=%h discard=%b expected word=%h discard=%b",
                     req, sw_none, dis_none, en, m_dis);
        end
    endtask

    // inputs already driven; clock them in and check after the edge
    task automatic step(string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(req);
        idle_inputs();
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired: time=%0t expected end before it", $time);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; tx_en = 0; rx_en = 0;
        idle_inputs();
        m_busy = 0; m_bufv = 0; m_err = 0; m_dis = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare("R1 reset state");

        // R3: load and done together -> busy set
        xfer_load = 1; xfer_done = 1; step("R3 load beats done");
        xfer_done = 1; step("R3 done clears busy");

        // R5 / R6 transmit path
        tx_en = 1;
        buf_wr = 1; step("R5 tx write sets bufv");
        xfer_load = 1; step("R6 load clears bufv in tx");
        // R7 overrun with back-to-back discard
        buf_wr = 1; step("R5 write");
        buf_wr = 1; step("R7 first overrun");
        buf_wr = 1; step("R7 second overrun");
        err_clr = 3'b001; step("R8 clear overrun");
        // R6 set wins over clear
        buf_wr = 1; xfer_load = 1; step("R6 set wins over load clear");
        // R4 cmd with overrun
        buf_wr = 1; cmd_stop = 1; step("R4 R7 cmd with overrun");
        // R5 receive path
        tx_en = 0; rx_en = 1;
        rx_store = 1; step("R5 rx store sets bufv");
        buf_rd = 1; step("R6 read clears bufv");
        // R5 reception error; R8 set vs clear
        err_parity = 1; err_clr = 3'b010; step("R8 set beats clear");
        err_frame = 1; step("R5 rx error sets bufv");
        step("R8 flags sticky");
        buf_wr = 1; step("R6 write in rx mode with rx_en");
        cmd_start = 1; xfer_load = 1; step("R4 start beats load");
        err_clr = 3'b111; step("R8 clear all");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) tx_en = 1'($urandom);
            if ($urandom_range(0, 15) == 0) rx_en = 1'($urandom);
            buf_wr     = ($urandom_range(0, 3) == 0);
            buf_rd     = ($urandom_range(0, 3) == 0);
            xfer_load  = ($urandom_range(0, 4) == 0);
            xfer_done  = ($urandom_range(0, 4) == 0);
            rx_store   = ($urandom_range(0, 4) == 0);
            err_frame  = ($urandom_range(0, 19) == 0);
            err_parity = ($urandom_range(0, 19) == 0);
            err_clr    = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000;
            cmd_start  = ($urandom_range(0, 31) == 0);
            cmd_stop   = ($urandom_range(0, 31) == 0);
            step("R2 R3 R4 R5 R6 R7 R8 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule